// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a watchdog that asks for a system reset when software fails to service it in time. Four control registers sit on a small register bus: a kick strobe, a reload value, a prescale divider and a run switch. Each is guarded by its own lock register, and the lock opens only after a fixed series of 16-bit key values is written to it. Reading a lock register returns its unlock progress in bits [1:0]. Writing a protected register through an open lock closes that lock again, so every write needs a fresh key series.

Once running, a prescaler divides the clock by (prescale + 1). Each prescaler tick lowers a countdown. When the countdown moves from one to zero, the block raises a one-cycle reset request and then stays at zero until the counter is reloaded. Software reloads the counter by writing 1 to the kick register. Setting the run switch also reloads it.

The register map uses 3-bit word addresses. Address 2k is the lock of register k, and address 2k+1 is register k itself, where k is 0 for kick, 1 for reload, 2 for prescale and 3 for run.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the timer is stopped, all four lock registers read 0, reload reads 0xFFFF, prescale reads 0, run reads 0 and `wdt_rst_o` is low.
- R2: The kick lock (address 0) reads 01 after key 0x5555 and 11 after a following key 0xAAAA.
- R3: The reload lock (address 2) opens with 0x6666 then 0xBBBB. The prescale lock (address 4) opens with 0x5A5A then 0xA5A5. Both read 01 and then 11.
- R4: The run lock (address 6) takes three keys, 0x7777, 0xCCCC and 0xDDDD, and reads 01, 10 and 11 after each one.
- R5: A wrong or out-of-order key returns that lock to 00. So does any write to a lock that already reads 11.
- R6: A write to a protected register (addresses 1, 3, 5, 7) whose lock does not read 11 leaves the register, the counter and the lock unchanged.
- R7: A write to a protected register whose lock reads 11 takes effect (subject to R8) and returns that lock to 00.
- R8: While the timer runs, writes to reload and prescale are discarded. The write still closes the lock.
- R9: Writing 1 to run (bit 0) starts a stopped timer, loads the counter from reload and restarts the prescaler. Writing 0 stops the timer, and the counter then holds its value.
- R10: With prescale P and reload R ≥ 1, `wdt_rst_o` goes high R·(P+1) clock edges after the edge that starts the timer or reloads the counter, and stays high for exactly one cycle.
- R11: After the reset request the counter stays at zero and no further request follows until a reload. A reload value of 0 never produces a request.
- R12: Writing a value with bit 0 set to the kick register (address 1) while the kick lock reads 11 reloads the counter and restarts the prescaler, which postpones the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data or key value |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
Read data is combinational, so the bench samples it in the same cycle the address is driven. A written key, register value or lock change becomes visible from the cycle after the write edge. The reset request is due R·(P+1) edges after the edge that starts or reloads the counter. The bench counts edges from the return of the write that caused it, sampling 1 ns after each rising edge, and compares the count exactly. It also checks the cycle after the request to confirm the pulse is one cycle wide. Quiet periods are checked with a pulse counter sampled on falling edges.

// File: rtl/wdt_kl_pkg.sv
package wdt_kl_pkg;

  localparam int KEY_W     = 16;
  localparam int MAX_KEYS  = 3;
  localparam int NUM_LOCKS = 4;
  localparam int ADDR_W    = 3;

  // register pair index: lock at {id,0}, protected register at {id,1}
  typedef enum logic [1:0] {
    LK_KICK = 2'd0,
    LK_LOAD = 2'd1,
    LK_DIV  = 2'd2,
    LK_RUN  = 2'd3
  } lock_id_e;

  // key series, first key in the lowest slice
  function automatic logic [MAX_KEYS*KEY_W-1:0] key_seq(input int id);
    case (id)
      0:       key_seq = {16'h0000, 16'hAAAA, 16'h5555};
      1:       key_seq = {16'h0000, 16'hBBBB, 16'h6666};
      2:       key_seq = {16'h0000, 16'hA5A5, 16'h5A5A};
      default: key_seq = {16'hDDDD, 16'hCCCC, 16'h7777};
    endcase
  endfunction

  function automatic int key_count(input int id);
    key_count = (id == 3) ? 3 : 2;
  endfunction

endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int KEY_W    = 16,
  parameter int MAX_KEYS = 3,
  parameter int NUM_KEYS = 2,
  parameter logic [MAX_KEYS*KEY_W-1:0] SEQ = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_we,
  input  logic [KEY_W-1:0] lock_wdata,
  input  logic             guard_we,
  output logic             open_o,
  output logic [1:0]       status_o
);
  localparam int CNT_W = $clog2(NUM_KEYS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [KEY_W-1:0] expect_key;

  assign open_o   = (cnt_q == CNT_W'(NUM_KEYS));
  assign status_o = open_o ? 2'b11 : 2'(cnt_q);

  always_comb begin
    expect_key = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (cnt_q == CNT_W'(i)) expect_key = SEQ[i*KEY_W +: KEY_W];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (lock_we) begin
      if (!open_o && (lock_wdata == expect_key)) cnt_d = cnt_q + 1'b1;
      else                                       cnt_d = '0;
    end else if (guard_we && open_o) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  relock_after_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_we && open_o && !lock_we) |=> (status_o == 2'b00));

  // R6
  idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_we && !guard_we) |=> $stable(status_o));

  // R5
  reopen_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && open_o) |=> (status_o == 2'b00));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick_o
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;

  assign tick_o = en && !restart && (pcnt_q == div);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart || !en) pcnt_d = '0;
    else if (tick_o)    pcnt_d = '0;
    else                pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R10
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (div != '0)) |=> !tick_o);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;

  assign expire_o = exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R11
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !load) |=> ((cnt_q == '0) && !expire_o));

  // R10
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (cnt_q == '0));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import wdt_kl_pkg::*;
#(
  parameter int DATA_W = KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_rst_o
);
  localparam logic [DATA_W-1:0] LOAD_RST = '1;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  // address decode
  logic [NUM_LOCKS-1:0] lock_we, data_we, lk_open;
  logic [1:0]           lk_status [NUM_LOCKS];

  always_comb begin
    for (int i = 0; i < NUM_LOCKS; i++) begin
      lock_we[i] = bus_we && (bus_addr == {2'(i), 1'b0});
      data_we[i] = bus_we && (bus_addr == {2'(i), 1'b1});
    end
  end

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    wdt_key_gate #(
      .KEY_W   (KEY_W),
      .MAX_KEYS(MAX_KEYS),
      .NUM_KEYS(key_count(g)),
      .SEQ     (key_seq(g))
    ) u_gate (
      .clk       (clk),
      .rst_n     (rst_s),
      .lock_we   (lock_we[g]),
      .lock_wdata(bus_wdata[KEY_W-1:0]),
      .guard_we  (data_we[g]),
      .open_o    (lk_open[g]),
      .status_o  (lk_status[g])
    );
  end

  // control registers
  logic [DATA_W-1:0] load_q, load_d, div_q, div_d;
  logic              en_q, en_d;
  logic              acc_kick, acc_load, acc_div, acc_run, reload;

  assign acc_kick = data_we[LK_KICK] && lk_open[LK_KICK];
  assign acc_load = data_we[LK_LOAD] && lk_open[LK_LOAD];
  assign acc_div  = data_we[LK_DIV]  && lk_open[LK_DIV];
  assign acc_run  = data_we[LK_RUN]  && lk_open[LK_RUN];

  always_comb begin
    load_d = load_q;
    div_d  = div_q;
    en_d   = en_q;
    if (acc_load && !en_q) load_d = bus_wdata;
    if (acc_div  && !en_q) div_d  = bus_wdata;
    if (acc_run)           en_d   = bus_wdata[0];
  end

  assign reload = (acc_kick && bus_wdata[0]) ||
                  (acc_run && bus_wdata[0] && !en_q);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      load_q <= LOAD_RST;
      div_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      load_q <= load_d;
      div_q  <= div_d;
      en_q   <= en_d;
    end
  end

  // timing path
  logic tick;

  wdt_prescaler #(.DIV_W(DATA_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_s),
    .en     (en_q),
    .restart(reload),
    .div    (div_q),
    .tick_o (tick)
  );

  wdt_countdown #(.CNT_W(DATA_W)) u_cdown (
    .clk     (clk),
    .rst_n   (rst_s),
    .load    (reload),
    .load_val(load_q),
    .tick    (tick),
    .expire_o(wdt_rst_o)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      {LK_LOAD, 1'b1}: bus_rdata = load_q;
      {LK_DIV,  1'b1}: bus_rdata = div_q;
      {LK_RUN,  1'b1}: bus_rdata = {{(DATA_W-1){1'b0}}, en_q};
      {LK_KICK, 1'b1}: bus_rdata = '0;
      default:         bus_rdata = {{(DATA_W-2){1'b0}}, lk_status[bus_addr[2:1]]};
    endcase
  end

  // R8
  load_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q && data_we[LK_LOAD]) |=> $stable(load_q));

  // R8
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q && data_we[LK_DIV]) |=> $stable(div_q));

  // R6
  run_guarded_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(data_we[LK_RUN] && lk_open[LK_RUN]) |=> $stable(en_q));

  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!en_q && !en_d) |=> !wdt_rst_o);

endmodule

// File: tb/sim_keyguard_wdt.sv
`timescale 1ns/1ps
module sim_keyguard_wdt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdt_rst_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  keyguard_wdt u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .wdt_rst_o(wdt_rst_o)
  );

  always @(negedge clk) if (wdt_rst_o) pulses++;

  typedef struct packed {
    logic [2:0]  wa;
    logic [15:0] wd;
    logic [2:0]  ra;
    logic [15:0] exp;
  } step_t;

  localparam int NSTEP = 20;
  localparam step_t TBL [NSTEP] = '{
    '{3'd0, 16'h5555, 3'd0, 16'h0001},  // R2 first key
    '{3'd0, 16'hAAAA, 3'd0, 16'h0003},  // R2 open
    '{3'd0, 16'h1234, 3'd0, 16'h0000},  // R5 write to open lock closes it
    '{3'd2, 16'h6666, 3'd2, 16'h0001},  // R3
    '{3'd2, 16'h6666, 3'd2, 16'h0000},  // R5 out of order
    '{3'd2, 16'h6666, 3'd2, 16'h0001},  // R3
    '{3'd2, 16'hBBBB, 3'd2, 16'h0003},  // R3 open
    '{3'd3, 16'h0010, 3'd3, 16'h0010},  // R7 accepted
    '{3'd3, 16'h0050, 3'd3, 16'h0010},  // R6 lock closed, ignored
    '{3'd4, 16'h5A5A, 3'd2, 16'h0000},  // R7 reload lock closed after use
    '{3'd4, 16'hA5A5, 3'd4, 16'h0003},  // R3 prescale lock open
    '{3'd5, 16'h0002, 3'd5, 16'h0002},  // R7 accepted
    '{3'd5, 16'h0007, 3'd5, 16'h0002},  // R6 ignored
    '{3'd6, 16'h7777, 3'd6, 16'h0001},  // R4
    '{3'd6, 16'hCCCC, 3'd6, 16'h0002},  // R4
    '{3'd6, 16'hCCCC, 3'd6, 16'h0000},  // R5 wrong key
    '{3'd6, 16'h7777, 3'd6, 16'h0001},  // R4
    '{3'd6, 16'hCCCC, 3'd6, 16'h0002},  // R4
    '{3'd6, 16'hDDDD, 3'd6, 16'h0003},  // R4 open
    '{3'd7, 16'h0000, 3'd6, 16'h0000}   // R7 run lock closed after use
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(posedge clk);
      #1 k++;
      if (wdt_rst_o) break;
    end
  endtask

  task automatic open_run();
    wr(3'd6, 16'h7777); wr(3'd6, 16'hCCCC); wr(3'd6, 16'hDDDD);
  endtask

  task automatic kick();
    wr(3'd0, 16'h5555); wr(3'd0, 16'hAAAA); wr(3'd1, 16'h0001);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int k, p0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 addr %0d", a), v, (a == 3) ? 16'hFFFF : 16'h0000);
    end
    check("R1 reset output", {15'd0, wdt_rst_o}, 16'h0000);

    for (int i = 0; i < NSTEP; i++) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd(TBL[i].ra, v);
      check($sformatf("table step %0d", i), v, TBL[i].exp);
    end

    // R9 R10: start, reload 16, prescale 2 -> 48 edges
    open_run();
    wr(3'd7, 16'h0001);
    wait_pulse(300, k);
    check("R10 pulse delay", 16'(k), 16'd48);
    @(posedge clk); #1;
    check("R10 pulse width", {15'd0, wdt_rst_o}, 16'h0000);
    repeat (100) @(posedge clk);
    check("R11 no second pulse", 16'(pulses), 16'd1);

    // R8 config frozen while running
    wr(3'd2, 16'h6666); wr(3'd2, 16'hBBBB); wr(3'd3, 16'h0005);
    rd(3'd3, v); check("R8 reload kept", v, 16'h0010);
    rd(3'd2, v); check("R8 reload lock closed", v, 16'h0000);
    wr(3'd4, 16'h5A5A); wr(3'd4, 16'hA5A5); wr(3'd5, 16'h0000);
    rd(3'd5, v); check("R8 prescale kept", v, 16'h0002);

    // R12 kick postpones request
    kick();
    p0 = pulses;
    repeat (20) @(posedge clk);
    kick();
    check("R12 no early pulse", 16'(pulses), 16'(p0));
    wait_pulse(300, k);
    check("R12 delay after kick", 16'(k), 16'd48);
    @(negedge clk); #1;
    check("R12 one pulse", 16'(pulses), 16'(p0 + 1));

    // R6 kick while locked is ignored
    wr(3'd1, 16'h0001);
    repeat (100) @(posedge clk);
    check("R6 locked kick ignored", 16'(pulses), 16'(p0 + 1));

    // R9 stop holds counter
    open_run(); wr(3'd7, 16'h0000);
    kick();
    repeat (100) @(posedge clk);
    check("R9 stopped no pulse", 16'(pulses), 16'(p0 + 1));
    rd(3'd7, v); check("R9 run reads 0", v, 16'h0000);

    // R9 restart loads counter
    open_run(); wr(3'd7, 16'h0001);
    wait_pulse(300, k);
    check("R9 restart delay", 16'(k), 16'd48);

    // R11 reload 0 never fires
    open_run(); wr(3'd7, 16'h0000);
    wr(3'd2, 16'h6666); wr(3'd2, 16'hBBBB); wr(3'd3, 16'h0000);
    rd(3'd3, v); check("R11 reload zero stored", v, 16'h0000);
    p0 = pulses;
    open_run(); wr(3'd7, 16'h0001);
    repeat (100) @(posedge clk);
    check("R11 zero reload quiet", 16'(pulses), 16'(p0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule